// File: doc/BRIEF.md
# Address Tenure Master Controller

This block is the master side of the address phase on a split-transaction processor bus. An internal requester hands it one transfer (address, transfer attributes and the cache way that the transfer will fill) over a valid/ready handshake. The controller captures the transfer, raises a request to the external arbiter, and waits for a grant. Once granted, it opens an address tenure. It pulses a one-cycle start strobe, raises the busy flag, and drives the captured address, attributes and way bits with their output enables. These values do not change until the slave acknowledges.

On the cycle after an acknowledge is sampled, every driven group is released to high impedance. In that same cycle the controller samples the retry input. If retry is high, the controller asks the arbiter for the bus again and replays the identical captured transfer. If retry is low, it pulses a one-cycle completion flag back to the requester and returns to idle.

A priority-snoop input is qualified by a configuration enable. While a tenure is open and both are high, an output allows one reserved queue slot to be used for snoop-hit pushes.

Back-pressure on the request port: `req_ready_o` is high only while the controller is idle. A transfer is taken on a rising edge where `req_valid_i` and `req_ready_o` are both high. While ready is low, the requester must hold its valid and payload. Anything it presents in that time has no effect.

Top module: `abt_master`

## Requirements
- R1: While `rst_n` is low, all output enables, `tenure_busy_o`, `start_o`, `bus_req_o`, `done_o` and `req_ready_o` are low, asynchronously and regardless of other inputs.
- R2: `req_ready_o` is high only in the idle state. The payload is captured on the edge where valid and ready are both high, and later changes on the request inputs do not alter the transfer.
- R3: From the cycle after acceptance, `bus_req_o` stays high and nothing is driven until `bus_grant_i` is sampled high.
- R4: `start_o` is high for exactly one cycle, in the cycle after the grant is sampled. `tenure_busy_o` and all output enables rise in that same cycle.
- R5: While `tenure_busy_o` is high and no acknowledge has been sampled, the address, attribute and way outputs stay driven and unchanged, holding the captured values.
- R6: An acknowledge sampled in any cycle of the tenure, including the start cycle, makes all output enables and `tenure_busy_o` low in the very next cycle.
- R7: Retry is sampled in the cycle after the acknowledge. If it is high, `bus_req_o` is high in the following cycle and the next tenure drives the same captured address, attributes and way.
- R8: If retry is low in the retry-sample cycle, `done_o` is high for one cycle in the following cycle, and `req_ready_o` is high in that cycle.
- R9: During the retry-sample cycle, `req_ready_o` and `start_o` are low, so no new request is taken and no new tenure starts before that cycle ends.
- R10: The way output is `WAYW` bits wide (1 to 3). Its value, enable and release timing are identical to the address output.
- R11: `rsv_slot_o` is high only while `tenure_busy_o`, `prio_cfg_en_i` and `prio_snoop_i` are all high.
- R12: Outside a tenure, `addr_ack_i`, `addr_retry_i` and `bus_grant_i` have no effect: no drive, no busy, no start and no completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Requester offers a transfer |
| req_ready_o | output | 1 | Controller idle and able to take a transfer |
| req_addr_i | input | AW | Transfer address |
| req_attr_i | input | TW | Transfer attributes |
| req_way_i | input | WAYW | Cache way to be replaced |
| done_o | output | 1 | One-cycle pulse: transfer finished without retry |
| bus_req_o | output | 1 | Request to external arbiter |
| bus_grant_i | input | 1 | Grant from external arbiter |
| start_o | output | 1 | One-cycle tenure start strobe |
| tenure_busy_o | output | 1 | Address bus owned and driven |
| addr_o | output | AW | Address value |
| addr_oe_o | output | 1 | Address output enable |
| attr_o | output | TW | Attribute value |
| attr_oe_o | output | 1 | Attribute output enable |
| way_o | output | WAYW | Way indicator value |
| way_oe_o | output | 1 | Way indicator output enable |
| addr_ack_i | input | 1 | Slave acknowledge of address phase |
| addr_retry_i | input | 1 | Retry request, valid in cycle after acknowledge |
| prio_cfg_en_i | input | 1 | Configuration enable for priority snoop |
| prio_snoop_i | input | 1 | Priority snoop request, held for the tenure |
| rsv_slot_o | output | 1 | Reserved snoop-push slot may be used |

## Verification
There are two coincidences to test. In the first, the tenure opens and closes together: the acknowledge is already high in the start cycle, so the start strobe, busy, the drives and the end-of-phase decision all fall on one cycle. The bench applies a zero-wait acknowledge and checks that every driver releases one cycle later.

In the second, the retry-sample cycle of one tenure meets a new request from the requester. The bench raises valid during that cycle and checks two things. First, ready and start stay low in that cycle. Second, the next cycle brings only the completion pulse and no bus request. The held request is then taken in the idle cycle.

// File: rtl/abt_pkg.sv
package abt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_REQ   = 3'd1,
    ST_START = 3'd2,
    ST_HOLD  = 3'd3,
    ST_RSAMP = 3'd4
  } abt_state_e;

  // States in which the address group is owned and driven.
  function automatic logic owns_bus(abt_state_e s);
    return (s == ST_START) || (s == ST_HOLD);
  endfunction

endpackage

// File: rtl/abt_seq.sv
module abt_seq
  import abt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire_i,
  input  logic grant_i,
  input  logic ack_i,
  input  logic retry_i,
  output logic load_o,
  output logic drive_nxt_o,
  output logic start_q_o,
  output logic busy_q_o,
  output logic ready_q_o,
  output logic done_q_o,
  output logic bus_req_o
);

  abt_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_fire_i) st_d = ST_REQ;
      ST_REQ:   if (grant_i)    st_d = ST_START;
      ST_START: st_d = ack_i ? ST_RSAMP : ST_HOLD;
      ST_HOLD:  if (ack_i)      st_d = ST_RSAMP;
      ST_RSAMP: st_d = retry_i ? ST_REQ : ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign load_o      = (st_q == ST_IDLE) && req_fire_i;
  assign drive_nxt_o = owns_bus(st_d);
  assign bus_req_o   = (st_q == ST_REQ);

  // Registered strobes: each reflects the state entered on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q_o <= 1'b0;
      busy_q_o  <= 1'b0;
      ready_q_o <= 1'b0;
      done_q_o  <= 1'b0;
    end else begin
      start_q_o <= (st_d == ST_START);
      busy_q_o  <= drive_nxt_o;
      ready_q_o <= (st_d == ST_IDLE);
      done_q_o  <= (st_q == ST_RSAMP) && !retry_i;
    end
  end

endmodule

// File: rtl/abt_capture.sv
module abt_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/abt_drive.sv
module abt_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_nxt_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic         oe_o
);

  // Registered pad stage: value and enable switch together on the edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o  <= '0;
      oe_o <= 1'b0;
    end else begin
      oe_o <= en_nxt_i;
      q_o  <= en_nxt_i ? d_i : '0;
    end
  end

endmodule

// File: rtl/abt_master.sv
module abt_master #(
  parameter int AW   = 32,
  parameter int TW   = 5,
  parameter int WAYW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [TW-1:0]   req_attr_i,
  input  logic [WAYW-1:0] req_way_i,
  output logic            done_o,
  output logic            bus_req_o,
  input  logic            bus_grant_i,
  output logic            start_o,
  output logic            tenure_busy_o,
  output logic [AW-1:0]   addr_o,
  output logic            addr_oe_o,
  output logic [TW-1:0]   attr_o,
  output logic            attr_oe_o,
  output logic [WAYW-1:0] way_o,
  output logic            way_oe_o,
  input  logic            addr_ack_i,
  input  logic            addr_retry_i,
  input  logic            prio_cfg_en_i,
  input  logic            prio_snoop_i,
  output logic            rsv_slot_o
);

  localparam int PW      = AW + TW + WAYW;
  localparam int ATTR_LO = WAYW;
  localparam int ADDR_LO = WAYW + TW;

  generate
    if (WAYW < 1 || WAYW > 3) begin : g_bad_way
      $error("abt_master: WAYW must lie in 1..3");
    end
  endgenerate

  logic          fire;
  logic          load;
  logic          drive_nxt;
  logic [PW-1:0] held;

  assign fire = req_valid_i && req_ready_o;

  abt_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_fire_i (fire),
    .grant_i    (bus_grant_i),
    .ack_i      (addr_ack_i),
    .retry_i    (addr_retry_i),
    .load_o     (load),
    .drive_nxt_o(drive_nxt),
    .start_q_o  (start_o),
    .busy_q_o   (tenure_busy_o),
    .ready_q_o  (req_ready_o),
    .done_q_o   (done_o),
    .bus_req_o  (bus_req_o)
  );

  abt_capture #(.W(PW)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(load),
    .d_i   ({req_addr_i, req_attr_i, req_way_i}),
    .q_o   (held)
  );

  abt_drive #(.W(AW)) u_drv_addr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_nxt_i(drive_nxt),
    .d_i     (held[ADDR_LO +: AW]),
    .q_o     (addr_o),
    .oe_o    (addr_oe_o)
  );

  abt_drive #(.W(TW)) u_drv_attr (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_nxt_i(drive_nxt),
    .d_i     (held[ATTR_LO +: TW]),
    .q_o     (attr_o),
    .oe_o    (attr_oe_o)
  );

  abt_drive #(.W(WAYW)) u_drv_way (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_nxt_i(drive_nxt),
    .d_i     (held[0 +: WAYW]),
    .q_o     (way_o),
    .oe_o    (way_oe_o)
  );

  assign rsv_slot_o = prio_cfg_en_i && prio_snoop_i && tenure_busy_o;

endmodule

// File: rtl/abt_master_chk.sv
module abt_master_chk #(
  parameter int AW   = 32,
  parameter int TW   = 5,
  parameter int WAYW = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready_o,
  input logic            done_o,
  input logic            bus_req_o,
  input logic            start_o,
  input logic            tenure_busy_o,
  input logic [AW-1:0]   addr_o,
  input logic            addr_oe_o,
  input logic [TW-1:0]   attr_o,
  input logic            attr_oe_o,
  input logic [WAYW-1:0] way_o,
  input logic            way_oe_o,
  input logic            addr_ack_i,
  input logic            addr_retry_i,
  input logic            prio_cfg_en_i,
  input logic            prio_snoop_i,
  input logic            rsv_slot_o
);

  assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> (!tenure_busy_o && !bus_req_o));

  assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  assert_start_drives_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (tenure_busy_o && addr_oe_o && attr_oe_o));

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_busy_o && !addr_ack_i) |=>
      (tenure_busy_o && addr_oe_o && $stable(addr_o) && $stable(attr_o) && $stable(way_o)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_busy_o && addr_ack_i) |=>
      (!addr_oe_o && !attr_oe_o && !way_oe_o && !tenure_busy_o));

  assert_rerequest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tenure_busy_o && addr_ack_i) && addr_retry_i) |=> (bus_req_o && !done_o));

  assert_done_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!$past(addr_retry_i) && req_ready_o));

  assert_sample_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tenure_busy_o && addr_ack_i) |=> (!start_o && !req_ready_o));

  assert_way_tracks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    way_oe_o == addr_oe_o);

  assert_rsv_qualified_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_slot_o |-> (prio_cfg_en_i && prio_snoop_i && tenure_busy_o));

endmodule

bind abt_master abt_master_chk #(.AW(AW), .TW(TW), .WAYW(WAYW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready_o  (req_ready_o),
  .done_o       (done_o),
  .bus_req_o    (bus_req_o),
  .start_o      (start_o),
  .tenure_busy_o(tenure_busy_o),
  .addr_o       (addr_o),
  .addr_oe_o    (addr_oe_o),
  .attr_o       (attr_o),
  .attr_oe_o    (attr_oe_o),
  .way_o        (way_o),
  .way_oe_o     (way_oe_o),
  .addr_ack_i   (addr_ack_i),
  .addr_retry_i (addr_retry_i),
  .prio_cfg_en_i(prio_cfg_en_i),
  .prio_snoop_i (prio_snoop_i),
  .rsv_slot_o   (rsv_slot_o)
);

// File: tb/abt_master_test.sv
`timescale 1ns/1ps
module abt_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [4:0]  req_attr = '0;
  logic [1:0]  req_way = '0;
  logic        done;
  logic        bus_req;
  logic        bus_grant = 1'b0;
  logic        start;
  logic        busy;
  logic [31:0] addr;
  logic        addr_oe;
  logic [4:0]  attr;
  logic        attr_oe;
  logic [1:0]  way;
  logic        way_oe;
  logic        ack = 1'b0;
  logic        retry = 1'b0;
  logic        pen = 1'b0;
  logic        psnp = 1'b0;
  logic        rsv;

  int nvec = 0;
  int nfail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  abt_master #(.AW(32), .TW(5), .WAYW(2)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_addr_i(req_addr), .req_attr_i(req_attr), .req_way_i(req_way),
    .done_o(done), .bus_req_o(bus_req), .bus_grant_i(bus_grant),
    .start_o(start), .tenure_busy_o(busy),
    .addr_o(addr), .addr_oe_o(addr_oe), .attr_o(attr), .attr_oe_o(attr_oe),
    .way_o(way), .way_oe_o(way_oe),
    .addr_ack_i(ack), .addr_retry_i(retry),
    .prio_cfg_en_i(pen), .prio_snoop_i(psnp), .rsv_slot_o(rsv)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  endtask

  // R1: everything quiet in reset, even with busy-looking inputs
  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b1; ack = 1'b1; bus_grant = 1'b1; pen = 1'b1; psnp = 1'b1;
    repeat (3) step();
    #1;
    chk("R1 addr_oe", addr_oe, 0);
    chk("R1 attr_oe", attr_oe, 0);
    chk("R1 way_oe", way_oe, 0);
    chk("R1 busy", busy, 0);
    chk("R1 start", start, 0);
    chk("R1 bus_req", bus_req, 0);
    chk("R1 ready", req_ready, 0);
    chk("R1 done", done, 0);
    req_valid = 1'b0; ack = 1'b0; bus_grant = 1'b0; pen = 1'b0; psnp = 1'b0;
    rst_n = 1'b1;
    step();
    #1;
    chk("R2 ready after reset", req_ready, 1);
  endtask

  // One tenure, with grant delay gd, ack delay ad, nret retries before success.
  task automatic tenure(input logic [31:0] a, input logic [4:0] t, input logic [1:0] w,
                        input int gd, input int ad, input int nret,
                        input logic en, input logic hp, input bit offer_next);
    req_valid = 1'b1; req_addr = a; req_attr = t; req_way = w; pen = en; psnp = hp;
    #1;
    chk("R2 ready in idle", req_ready, 1);
    step();
    req_valid = 1'b0; req_addr = ~a; req_attr = ~t; req_way = ~w;
    #1;
    for (int r = 0; r <= nret; r++) begin
      for (int i = 0; i < gd; i++) begin
        chk("R3 bus request held", bus_req, 1);
        chk("R3 no drive before grant", addr_oe, 0);
        step();
        #1;
      end
      bus_grant = 1'b1;
      #1;
      chk("R3 bus request at grant", bus_req, 1);
      step();
      bus_grant = 1'b0;
      for (int i = 0; i <= ad; i++) begin
        if (i == ad) ack = 1'b1;
        #1;
        chk("R4 start strobe", start, (i == 0));
        chk("R5 busy", busy, 1);
        chk("R5 addr_oe", addr_oe, 1);
        chk("R5 attr_oe", attr_oe, 1);
        chk("R5 addr held", addr, a);
        chk("R5 attr held", attr, t);
        chk("R10 way value", way, w);
        chk("R10 way_oe", way_oe, 1);
        chk("R11 reserved slot", rsv, en & hp);
        chk("R2 ready low in tenure", req_ready, 0);
        step();
        ack = 1'b0;
      end
      retry = (r < nret);
      if (offer_next && r == nret) req_valid = 1'b1;
      #1;
      chk("R6 addr released", addr_oe, 0);
      chk("R6 attr released", attr_oe, 0);
      chk("R10 way released", way_oe, 0);
      chk("R6 busy low", busy, 0);
      chk("R9 ready low in sample", req_ready, 0);
      chk("R9 no start in sample", start, 0);
      chk("R11 no slot after release", rsv, 0);
      step();
      retry = 1'b0;
      #1;
      if (r < nret) begin
        chk("R7 re-request after retry", bus_req, 1);
        chk("R7 no done after retry", done, 0);
      end else begin
        chk("R8 done pulse", done, 1);
        chk("R8 ready with done", req_ready, 1);
        chk("R9 no request from sample-cycle offer", bus_req, 0);
      end
    end
  endtask

  // R12: stray acknowledge, retry and grant while idle
  task automatic t_idle_ignore();
    ack = 1'b1; retry = 1'b1; bus_grant = 1'b1; pen = 1'b1; psnp = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      #1;
      chk("R12 idle busy", busy, 0);
      chk("R12 idle drive", addr_oe, 0);
      chk("R12 idle start", start, 0);
      chk("R12 idle done", done, 0);
      chk("R12 idle bus_req", bus_req, 0);
      chk("R11 idle slot", rsv, 0);
    end
    ack = 1'b0; retry = 1'b0; bus_grant = 1'b0; pen = 1'b0; psnp = 1'b0;
    step();
  endtask

  // R1: reset in the middle of a tenure releases at once
  task automatic t_reset_mid();
    req_valid = 1'b1; req_addr = 32'hCAFE_0000; req_attr = 5'h3; req_way = 2'd1;
    step();
    req_valid = 1'b0; bus_grant = 1'b1;
    step();
    bus_grant = 1'b0;
    #1;
    chk("R4 drive before mid reset", addr_oe, 1);
    rst_n = 1'b0;
    #1;
    chk("R1 async release addr", addr_oe, 0);
    chk("R1 async release way", way_oe, 0);
    chk("R1 async busy low", busy, 0);
    step();
    rst_n = 1'b1;
    step();
  endtask

  initial begin
    #(200000 * 10);
    nfail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    t_reset();
    tenure(32'h1000_0040, 5'h0A, 2'd2, 0, 0, 0, 1'b0, 1'b0, 1'b0);
    tenure(32'h2345_6780, 5'h15, 2'd1, 3, 4, 0, 1'b1, 1'b1, 1'b0);
    tenure(32'hDEAD_BEE0, 5'h1F, 2'd3, 1, 2, 2, 1'b1, 1'b0, 1'b0);
    tenure(32'h0000_0100, 5'h01, 2'd0, 0, 1, 1, 1'b0, 1'b1, 1'b1);
    tenure(32'hFFFF_FFE0, 5'h10, 2'd2, 2, 0, 0, 1'b1, 1'b1, 1'b0);
    t_idle_ignore();
    t_reset_mid();
    tenure(32'h7654_3210, 5'h07, 2'd1, 0, 0, 1, 1'b0, 1'b0, 1'b0);
    summary();
  end

endmodule